// File: doc/BRIEF.md
# Clock-Stop Serial Peripheral Master

This block is a synchronous SPI master that creates its serial clock from the system clock. The serial clock runs only while a word is being moved. Between words the clock rests at logic high. A host loads a divide value, a word length and a transmit word, then pulses a start strobe. The block drops its active-low select line and presents the most significant data bit at once. After one high phase it begins clocking. It drives each new bit after a falling serial clock edge and samples the incoming line on each rising edge.

When the last bit has been sampled, the clock stays high for one more high phase. The select line then rises, the data output enable drops, and a one-cycle done pulse appears. At the same moment the received word is published, right-aligned. The serial period is the divide value plus one system cycles. When that period is odd, the high phase is one cycle longer than the low phase.

Top module: `spi_clkstop_master`

## Requirements
- R1: After reset, with no transfer active: ss_n = 1, sclk = 1, mosi_oe = 0, done = 0 and rx_word = 0.
- R2: A divide value d of 0 is treated as 1. The serial clock period is P = d+1 system cycles. The high phase lasts H = floor(d/2)+1 cycles and the low phase lasts L = P-H cycles.
- R3: A start sampled high while idle is accepted. In the next cycle ss_n = 0, mosi_oe = 1 and mosi carries bit n-1 of tx_word. sclk stays high for H cycles before the first falling edge.
- R4: mosi changes only on a falling sclk edge. The bits go out in the order n-1 down to 0, and the first falling edge keeps bit n-1.
- R5: miso is sampled at every rising sclk edge. Bit n-1 is sampled first. rx_word holds the n sampled bits in bits n-1..0 with zeros above, and it changes only when done rises.
- R6: After the n-th rising edge, sclk stays high for H cycles. ss_n then returns to 1, mosi_oe returns to 0 and done is 1 for exactly one cycle. ss_n stays low for H + n*P cycles in total.
- R7: The word length n is word_len limited to the range 4..MAX_LEN: a smaller value gives 4 and a larger value gives MAX_LEN.
- R8: A start while a transfer is active is ignored, including in the transfer's last cycle. A start sampled in the cycle where done is 1 is accepted.
- R9: Each transfer has exactly n falling sclk edges, and sclk is 1 whenever ss_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Divide value, latched at start |
| word_len | input | LEN_W | Word length in bits, latched at start |
| start | input | 1 | Transfer request strobe |
| tx_word | input | MAX_LEN | Word to send, right-aligned |
| rx_word | output | MAX_LEN | Last received word, right-aligned |
| done | output | 1 | One-cycle pulse when a transfer ends |
| sclk | output | 1 | Serial clock, idle high |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for mosi |
| miso | input | 1 | Serial data in |

## Verification
Two events can fall in the same cycle: the end of a transfer, shown by the done pulse, and a new start request. The bench raises start in the very cycle where done is seen high, so the next transfer must begin with no idle gap. It also raises start in the middle of a transfer, and that request must have no effect. A behavioural reference model rebuilds the expected waveforms from the period and phase formulas and compares every output on every clock. This shows whether the collided request was accepted or dropped, and whether the received word and edge count stay correct around it.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LEAD = 2'd1,
      PH_LOW  = 2'd2,
      PH_HIGH = 2'd3
   } spim_phase_e;
endpackage

// File: rtl/spim_phase_timer.sv
module spim_phase_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [DIV_W-1:0] div_in,
   input  logic             load_hi,
   input  logic             load_lo,
   output logic             expired
);
   logic [DIV_W-1:0] d_q, cnt_q, d_arm;
   logic [DIV_W:0]   lo_m1;

   // zero divide behaves as one (R2)
   assign d_arm = (div_in == '0) ? DIV_W'(1) : div_in;
   // low phase minus one: ceil(d/2)-1
   assign lo_m1 = ((({1'b0, d_q}) + 1'b1) >> 1) - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_q   <= DIV_W'(1);
         cnt_q <= '0;
      end else if (arm) begin
         d_q   <= d_arm;
         cnt_q <= d_arm >> 1;           // high phase minus one
      end else if (load_hi) begin
         cnt_q <= d_q >> 1;
      end else if (load_lo) begin
         cnt_q <= lo_m1[DIV_W-1:0];
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter int MAX_LEN = 32,
   parameter int LEN_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [LEN_W-1:0]   len,
   input  logic [MAX_LEN-1:0] tx,
   input  logic               shift,
   input  logic               capture,
   input  logic               publish,
   input  logic               miso,
   output logic               mosi_bit,
   output logic [MAX_LEN-1:0] rx_word
);
   logic [MAX_LEN-1:0] tx_sh, rx_sh, rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         rx_sh <= '0;
         rx_q  <= '0;
      end else begin
         if (load)
            tx_sh <= tx << (MAX_LEN - int'(len));
         else if (shift)
            tx_sh <= tx_sh << 1;
         if (load)
            rx_sh <= '0;
         else if (capture)
            rx_sh <= {rx_sh[MAX_LEN-2:0], miso};
         if (publish)
            rx_q <= rx_sh;
      end
   end

   assign mosi_bit = tx_sh[MAX_LEN-1];
   assign rx_word  = rx_q;
endmodule

// File: rtl/spi_clkstop_master.sv
module spi_clkstop_master #(
   parameter int DIV_W   = 8,
   parameter int MAX_LEN = 32,
   parameter int MIN_LEN = 4,
   localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIV_W-1:0]   div_val,
   input  logic [LEN_W-1:0]   word_len,
   input  logic               start,
   input  logic [MAX_LEN-1:0] tx_word,
   output logic [MAX_LEN-1:0] rx_word,
   output logic               done,
   output logic               sclk,
   output logic               ss_n,
   output logic               mosi,
   output logic               mosi_oe,
   input  logic               miso
);
   import spim_pkg::*;

   generate
      if (MIN_LEN < 2 || MIN_LEN > MAX_LEN) begin : g_bad_len
         $error("spi_clkstop_master: MIN_LEN must lie in 2..MAX_LEN");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_clkstop_master: DIV_W must be at least 1");
      end
   endgenerate

   spim_phase_e      ph_q;
   logic [LEN_W-1:0] len_q, len_c, bit_q;
   logic             sclk_q, ss_n_q, done_q;
   logic             accept, expired, last, go_low, go_high, finish, shift;
   logic             mosi_bit;

   // length limited to MIN_LEN..MAX_LEN (R7)
   always_comb begin
      if (word_len < LEN_W'(MIN_LEN))      len_c = LEN_W'(MIN_LEN);
      else if (word_len > LEN_W'(MAX_LEN)) len_c = LEN_W'(MAX_LEN);
      else                                 len_c = word_len;
   end

   assign accept  = (ph_q == PH_IDLE) && start;   // busy start ignored (R8)
   assign last    = (bit_q == len_q - 1'b1);
   assign go_low  = expired && ((ph_q == PH_LEAD) || (ph_q == PH_HIGH && !last));
   assign go_high = expired && (ph_q == PH_LOW);
   assign finish  = expired && (ph_q == PH_HIGH) && last;
   assign shift   = expired && (ph_q == PH_HIGH) && !last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         len_q  <= LEN_W'(MIN_LEN);
         bit_q  <= '0;
         sclk_q <= 1'b1;
         ss_n_q <= 1'b1;
         done_q <= 1'b0;
      end else begin
         done_q <= finish;
         if (accept) begin
            ph_q   <= PH_LEAD;
            len_q  <= len_c;
            bit_q  <= '0;
            ss_n_q <= 1'b0;
         end else if (go_low) begin
            ph_q   <= PH_LOW;
            sclk_q <= 1'b0;
            if (shift) bit_q <= bit_q + 1'b1;
         end else if (go_high) begin
            ph_q   <= PH_HIGH;
            sclk_q <= 1'b1;
         end else if (finish) begin
            ph_q   <= PH_IDLE;
            ss_n_q <= 1'b1;
         end
      end
   end

   spim_phase_timer #(.DIV_W(DIV_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (accept),
      .div_in  (div_val),
      .load_hi (go_high),
      .load_lo (go_low),
      .expired (expired)
   );

   spim_shifter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .len      (len_c),
      .tx       (tx_word),
      .shift    (shift),
      .capture  (go_high),
      .publish  (finish),
      .miso     (miso),
      .mosi_bit (mosi_bit),
      .rx_word  (rx_word)
   );

   assign sclk    = sclk_q;
   assign ss_n    = ss_n_q;
   assign done    = done_q;
   assign mosi_oe = !ss_n_q;
   assign mosi    = mosi_oe & mosi_bit;

   a_r9_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n |-> sclk);
   a_r6_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(ss_n));
   a_r6_oe_tracks_select: assert property (@(posedge clk) disable iff (!rst_n)
      mosi_oe == !ss_n);
   a_r3_select_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ss_n) |-> (sclk && mosi_oe));
   a_r4_mosi_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!ss_n && $past(!ss_n) && !$fell(sclk)) |-> $stable(mosi));
   a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != PH_IDLE && !finish) |=> !$fell(ss_n));
endmodule

// File: tb/spi_clkstop_master_tb_top.sv
module spi_clkstop_master_tb_top;
   localparam int DIV_W = 8, MAX_LEN = 32, MIN_LEN = 4;
   localparam int LEN_W = $clog2(MAX_LEN + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic [DIV_W-1:0] div_val = '0;
   logic [LEN_W-1:0] word_len = LEN_W'(8);
   logic start = 1'b0, miso = 1'b0;
   logic [MAX_LEN-1:0] tx_word = '0, rx_word;
   logic done, sclk, ss_n, mosi, mosi_oe;
   logic [MAX_LEN-1:0] slave_word = '0;

   always #5 clk = ~clk;

   spi_clkstop_master #(.DIV_W(DIV_W), .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .div_val(div_val), .word_len(word_len),
      .start(start), .tx_word(tx_word), .rx_word(rx_word), .done(done),
      .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso));

   int vectors = 0, fails = 0, cyc = 0, xfers = 0;
   bit run = 0;
   string tag = "R1";

   // reference model state
   bit m_act = 0, m_done = 0;
   int m_p, m_n, m_d, m_fall;
   logic [MAX_LEN-1:0] m_tx, m_slv, m_rx = '0;

   task automatic check(string t, string what, longint act, longint exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", t, what, cyc, act, exp);
      end
   endtask

   always @(negedge clk) if (run) begin
      int hh, ll, pp, b, r;
      logic e_sclk;
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
      b = 0; r = 1; e_sclk = 1'b1;
      if (m_act) begin
         hh = m_d / 2 + 1; pp = m_d + 1; ll = pp - hh;   // R2 phase formulas
         if (m_p >= hh) begin
            b = (m_p - hh) / pp; r = (m_p - hh) % pp;
            e_sclk = (r < ll) ? 1'b0 : 1'b1;
         end
         if (m_p >= hh && r == 0) m_fall++;
      end
      check({tag, " R2/R9"}, "sclk", sclk, e_sclk);
      check({tag, " R3/R6"}, "ss_n", ss_n, !m_act);
      check({tag, " R6"}, "mosi_oe", mosi_oe, m_act);
      check({tag, " R6"}, "done", done, m_done);
      check({tag, " R5"}, "rx_word", rx_word, m_rx);
      if (m_act) check({tag, " R3/R4"}, "mosi", mosi, m_tx[m_n-1-b]);
      if (m_act) miso = m_slv[m_n-1-b];
      // advance model to next cycle
      if (m_act) begin
         if (m_p == hh + m_n * pp - 1) begin
            m_act = 0; m_done = 1;
            m_rx = MAX_LEN'(m_slv & ((64'd1 << m_n) - 1));
            check({tag, " R9"}, "falling edge count", m_fall, m_n);
            xfers++;
         end else m_p++;
      end else begin
         m_done = 0;
         if (start) begin
            m_act = 1; m_p = 0; m_fall = 0;
            m_n = (int'(word_len) < MIN_LEN) ? MIN_LEN :
                  (int'(word_len) > MAX_LEN) ? MAX_LEN : int'(word_len);   // R7
            m_d = (div_val == 0) ? 1 : int'(div_val);
            m_tx = tx_word; m_slv = slave_word;
         end
      end
   end

   task automatic pulse_start();
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic wait_done();
      do begin @(posedge clk); #1; end while (!done);
   endtask

   task automatic xfer(string t, int d, int n, logic [31:0] tx, logic [31:0] sl);
      tag = t;
      div_val = DIV_W'(d); word_len = LEN_W'(n); tx_word = tx; slave_word = sl;
      @(posedge clk); #1;
      pulse_start();
      wait_done();
      repeat (2) @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      run = 1;
      repeat (3) @(posedge clk); #1;             // R1 idle checks
      xfer("R2 d1 n8",  1, 8,  32'hA5, 32'h3C);
      xfer("R2 d2 n8",  2, 8,  32'h5A, 32'hC3);
      xfer("R2 d3 n13", 3, 13, 32'h1ABC, 32'h0F0F);
      xfer("R2 d4 n4",  4, 4,  32'h9, 32'h6);
      xfer("R2 d7 n32", 7, 32, 32'hDEADBEEF, 32'h12345678);
      xfer("R2 d0 n5",  0, 5,  32'h15, 32'h0A);
      xfer("R7 short",  2, 2,  32'hFFFF_FFF3, 32'hFFFF_FFFA);
      xfer("R7 long",   1, 40, 32'h8000_0001, 32'hF00D_CAFE);
      // R8: start while busy has no effect
      tag = "R8 busy";
      div_val = 3; word_len = 8; tx_word = 32'hC6; slave_word = 32'h39;
      @(posedge clk); #1;
      pulse_start();
      repeat (6) @(posedge clk); #1;
      tx_word = 32'h11; div_val = 1; word_len = 4;
      pulse_start();
      wait_done();
      // R8: start in the done cycle is accepted back to back
      tag = "R8 back2back";
      tx_word = 32'h2B; slave_word = 32'hD4; div_val = 2; word_len = 6;
      pulse_start();
      wait_done();
      repeat (4) @(posedge clk); #1;
      check("R8", "transfers completed", xfers, 10);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule